// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block steps the input multiplexer of a 16-input analog-to-digital converter through a programmable window of channels and issues the conversion starts. A range write sets an inclusive window, with the lower limit in the low nibble and the upper limit in the high nibble. The write also returns the current channel to the lower limit and holds the block busy for a settling period. A start can come from a software command pulse or, when hardware triggering is on, from one of two sources: an internal timer tick or the rising edge of an external pin.

There are two modes. In single mode each accepted trigger produces one conversion and an end-of-conversion event. In scan mode one trigger produces a burst of conversions that runs from the current channel up to and including the upper limit. The samples in a burst are spaced by one of two fixed gaps, and busy stays high from the trigger until the last sample. The converter is modelled as a start pulse followed some cycles later by a one-cycle done pulse carrying the sample. Each sample goes out on a one-cycle valid strobe together with its channel number.

Triggers that arrive while the block is busy are discarded and recorded in a sticky missed flag. All timing is in clock cycles. The defaults assume a 10 MHz clock: 100 cycles of settling, and gaps of 50 or 93 cycles.

Top module: `adc_scan_seq`

## Requirements
- R1: `range_data[3:0]` is the lower limit and `range_data[7:4]` is the upper limit. A `range_wr` pulse loads both, and `cur_chan` equals the lower limit in the cycle after the write.
- R2: After a `range_wr` pulse, `busy` is high for exactly SETTLE_CYC (default 100) consecutive cycles and then falls, unless a conversion is triggered.
- R3: Each `conv_start` pulse carries on `conv_chan` the value `cur_chan` had before it. `cur_chan` then moves to that value plus one, or to the lower limit if that value was the upper limit.
- R4: With `hw_trig_en`=0 only `sw_start` starts a conversion. With `hw_trig_en`=1, `sw_start` is ignored. In that case `trig_src_sel`=1 selects `timer_tick`, and `trig_src_sel`=0 selects a rising edge of `ext_pin`, so a pin held high starts only one conversion.
- R5: In single mode (`scan_en`=0 at the trigger) an accepted trigger gives exactly one `conv_start`. `busy` stays high from the cycle after the trigger until the sample is delivered, and `eoc` pulses together with that sample.
- R6: In scan mode (`scan_en`=1 at the trigger) one trigger converts every channel from `cur_chan` up to the upper limit. `busy` stays high through the whole burst, `eos` pulses only with the last sample, and `eoc` does not pulse. When the two limits are equal, the burst is a single conversion.
- R7: Within a scan, the next `conv_start` rises GAP cycles after the cycle in which `conv_done` was accepted. GAP is GAP_FAST_CYC (50) when `gap_sel`=1 at the trigger, and GAP_SLOW_CYC (93) when `gap_sel`=0.
- R8: A trigger that arrives while `busy` is high, or in the same cycle as `range_wr`, starts nothing. It sets `missed`, which stays set until reset.
- R9: `smp_valid` pulses in the cycle after `conv_done` is accepted during a conversion, with `smp_data` equal to `conv_data` and `smp_chan` equal to that conversion's channel. A `conv_done` pulse while no conversion is pending is ignored.
- R10: The synchronous reset `rst` leaves the block idle with `busy`=0, `missed`=0, both limits and `cur_chan` at 0, and no strobes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| range_wr | input | 1 | Range register write strobe |
| range_data | input | 8 | Upper limit [7:4], lower limit [3:0] |
| hw_trig_en | input | 1 | 1: hardware trigger, software start ignored |
| trig_src_sel | input | 1 | 1: timer tick, 0: external pin rising edge |
| timer_tick | input | 1 | Internal timer output pulse |
| ext_pin | input | 1 | External trigger pin (synchronous) |
| sw_start | input | 1 | Software start command pulse |
| scan_en | input | 1 | 1: scan burst per trigger |
| gap_sel | input | 1 | 1: short gap, 0: long gap |
| conv_start | output | 1 | Conversion start pulse to converter |
| conv_chan | output | 4 | Multiplexer channel of current conversion |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 16 | Converter sample, valid with conv_done |
| smp_valid | output | 1 | Sample strobe to downstream buffer |
| smp_chan | output | 4 | Channel of delivered sample |
| smp_data | output | 16 | Delivered sample |
| eoc | output | 1 | End-of-conversion event (single mode) |
| eos | output | 1 | End-of-scan event (scan mode) |
| busy | output | 1 | Settling or conversion activity |
| cur_chan | output | 4 | Channel the next conversion will use |
| missed | output | 1 | Sticky dropped-trigger flag |

## Verification
Repeated single software starts over a window step the channel across the upper limit. This shows a correct wrap to the lower limit apart from a wrap to zero or to the top of the 4-bit range. Each of the three trigger sources is then tried while the other two are active and should be ignored; a held pin and a software start under hardware mode show that only the selected source and a rising edge count. Scans are run with both gap settings and with a one-channel window. Random windows, modes and gaps mixed with these show that the burst length, the placement of `eos` and the gap spacing follow the window and do not depend on fixed values. A second trigger during a conversion and a stray done pulse while idle show that dropped events leave the channel and sample stream untouched.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W  = 4;
    localparam int SMP_W = 16;

    typedef logic [CH_W-1:0] chan_t;

    typedef struct packed {
        chan_t hi;
        chan_t lo;
    } range_t;

    typedef struct packed {
        chan_t             chan;
        logic [SMP_W-1:0]  data;
    } sample_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SETTLE = 2'd1,
        S_CONV   = 2'd2,
        S_GAP    = 2'd3
    } seq_state_e;

    // channel that follows cur inside the window r
    function automatic chan_t step_chan(chan_t cur, range_t r);
        if (cur == r.hi) return r.lo;
        return chan_t'(cur + 1'b1);
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/seq_trig_sel.sv
module seq_trig_sel (
    input  logic clk,
    input  logic rst,
    input  logic hw_en,
    input  logic src_int,
    input  logic tick,
    input  logic ext_pin,
    input  logic sw_start,
    output logic trig
);
    logic ext_q;
    logic ext_rise;

    always_ff @(posedge clk) begin
        if (rst) ext_q <= 1'b0;
        else     ext_q <= ext_pin;
    end

    assign ext_rise = ext_pin & ~ext_q;

    always_comb begin
        if (hw_en) trig = src_int ? tick : ext_rise;
        else       trig = sw_start;
    end

    // a pin that was already high gives no further trigger
    assert_ext_level_R4: assert property (@(posedge clk) disable iff (rst)
        (hw_en && !src_int && $past(ext_pin) && ext_pin) |-> !trig);

endmodule

// File: rtl/seq_downcnt.sv
module seq_downcnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    assert_cnt_moves_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/seq_chan_step.sv
module seq_chan_step
    import adc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  range_t load_rng,
    input  logic   adv,
    output range_t rng,
    output chan_t  cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rng <= '0;
            cur <= '0;
        end else if (load) begin
            rng <= load_rng;
            cur <= load_rng.lo;
        end else if (adv) begin
            cur <= step_chan(cur, rng);
        end
    end

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && cur == rng.hi) |=> (cur == $past(rng.lo)));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && cur != rng.hi) |=> (cur == chan_t'($past(cur) + 1'b1)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(cur));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int SETTLE_CYC   = 100,
    parameter int GAP_FAST_CYC = 50,
    parameter int GAP_SLOW_CYC = 93
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              range_wr,
    input  logic [2*CH_W-1:0] range_data,
    input  logic              hw_trig_en,
    input  logic              trig_src_sel,
    input  logic              timer_tick,
    input  logic              ext_pin,
    input  logic              sw_start,
    input  logic              scan_en,
    input  logic              gap_sel,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [SMP_W-1:0]  conv_data,
    output logic              smp_valid,
    output logic [CH_W-1:0]   smp_chan,
    output logic [SMP_W-1:0]  smp_data,
    output logic              eoc,
    output logic              eos,
    output logic              busy,
    output logic [CH_W-1:0]   cur_chan,
    output logic              missed
);
    localparam int CNT_W = $clog2(max3(SETTLE_CYC, GAP_FAST_CYC, GAP_SLOW_CYC) + 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] FAST_LD   = CNT_W'(GAP_FAST_CYC - 1);
    localparam logic [CNT_W-1:0] SLOW_LD   = CNT_W'(GAP_SLOW_CYC - 1);

    seq_state_e       state;
    logic             trig;
    logic             cnt_zero;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             start_now;
    logic             accept;
    logic             scan_q;
    logic             gap_q;
    logic             last_in_scan;
    range_t           rng;
    chan_t            cur;
    chan_t            act_chan;
    sample_t          smp_q;

    seq_trig_sel u_trig (
        .clk      (clk),
        .rst      (rst),
        .hw_en    (hw_trig_en),
        .src_int  (trig_src_sel),
        .tick     (timer_tick),
        .ext_pin  (ext_pin),
        .sw_start (sw_start),
        .trig     (trig)
    );

    seq_downcnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    seq_chan_step u_chan (
        .clk      (clk),
        .rst      (rst),
        .load     (range_wr),
        .load_rng (range_t'(range_data)),
        .adv      (start_now),
        .rng      (rng),
        .cur      (cur)
    );

    assign accept       = (state == S_CONV) && conv_done && !range_wr;
    assign last_in_scan = (act_chan == rng.hi);

    always_comb begin
        start_now = 1'b0;
        if (!range_wr) begin
            if (state == S_IDLE && trig)    start_now = 1'b1;
            if (state == S_GAP && cnt_zero) start_now = 1'b1;
        end
        cnt_load = range_wr || (accept && scan_q && !last_in_scan);
        if (range_wr)   cnt_val = SETTLE_LD;
        else if (gap_q) cnt_val = FAST_LD;
        else            cnt_val = SLOW_LD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            scan_q <= 1'b0;
            gap_q  <= 1'b0;
        end else if (range_wr) begin
            state <= S_SETTLE;
        end else begin
            unique case (state)
                S_IDLE: if (trig) begin
                    state  <= S_CONV;
                    scan_q <= scan_en;
                    gap_q  <= gap_sel;
                end
                S_SETTLE: if (cnt_zero) state <= S_IDLE;
                S_CONV: if (conv_done) state <= (scan_q && !last_in_scan) ? S_GAP : S_IDLE;
                S_GAP: if (cnt_zero) state <= S_CONV;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_start <= 1'b0;
            act_chan   <= '0;
            smp_valid  <= 1'b0;
            smp_q      <= '0;
            eoc        <= 1'b0;
            eos        <= 1'b0;
            missed     <= 1'b0;
        end else begin
            conv_start <= start_now;
            if (start_now) act_chan <= cur;
            smp_valid <= accept;
            if (accept) smp_q <= '{chan: act_chan, data: conv_data};
            eoc <= accept && !scan_q;
            eos <= accept && scan_q && last_in_scan;
            if (trig && (state != S_IDLE || range_wr)) missed <= 1'b1;
        end
    end

    assign conv_chan = act_chan;
    assign smp_chan  = smp_q.chan;
    assign smp_data  = smp_q.data;
    assign busy      = (state != S_IDLE);
    assign cur_chan  = cur;

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (!busy && cur_chan == '0 && !missed && !smp_valid && !conv_start));

    assert_settle_R2: assert property (@(posedge clk) disable iff (rst)
        range_wr |=> (busy && cur_chan == $past(range_data[CH_W-1:0])));

    assert_hw_blocks_sw_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && hw_trig_en && trig_src_sel && !timer_tick && !range_wr) |=> !conv_start);

    assert_start_busy_R5: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> busy);

    assert_eos_last_R6: assert property (@(posedge clk) disable iff (rst)
        eos |-> (smp_valid && smp_chan == rng.hi && !eoc));

    assert_missed_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        missed |=> missed);

    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && trig) |=> missed);

    assert_stray_done_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && conv_done) |=> !smp_valid);

endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
    import adc_seq_pkg::*;

    localparam int SETTLE = 100;
    localparam int FAST   = 50;
    localparam int SLOW   = 93;
    localparam int LAT    = 4;
    localparam int LOGN   = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        range_wr = 1'b0;
    logic [7:0]  range_data = '0;
    logic        hw_trig_en = 1'b0;
    logic        trig_src_sel = 1'b0;
    logic        timer_tick = 1'b0;
    logic        ext_pin = 1'b0;
    logic        sw_start = 1'b0;
    logic        scan_en = 1'b0;
    logic        gap_sel = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = '0;
    logic        conv_start, smp_valid, eoc, eos, busy, missed;
    logic [3:0]  conv_chan, smp_chan, cur_chan;
    logic [15:0] smp_data;

    adc_scan_seq u_dut (
        .clk(clk), .rst(rst), .range_wr(range_wr), .range_data(range_data),
        .hw_trig_en(hw_trig_en), .trig_src_sel(trig_src_sel), .timer_tick(timer_tick),
        .ext_pin(ext_pin), .sw_start(sw_start), .scan_en(scan_en), .gap_sel(gap_sel),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_data(conv_data), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_data(smp_data), .eoc(eoc), .eos(eos), .busy(busy),
        .cur_chan(cur_chan), .missed(missed)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    int st_chan [LOGN];
    int st_cyc  [LOGN];
    int dn_cyc  [LOGN];
    int dn_data [LOGN];
    int sm_chan [LOGN];
    int sm_data [LOGN];
    int sm_eoc  [LOGN];
    int sm_eos  [LOGN];
    int n_st = 0, n_dn = 0, n_sm = 0, n_bfall = 0, n_eoc = 0, n_eos = 0;
    int stray_req = 0, stray_ack = 0;

    initial forever #5 clk = ~clk;
    initial forever begin @(posedge clk); cyc++; end

    // converter model and output logger
    initial begin
        int lat = 0;
        bit busy_prev = 0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (busy_prev && !busy) n_bfall++;
            busy_prev = busy;
            if (eoc) n_eoc++;
            if (eos) n_eos++;
            if (smp_valid && n_sm < LOGN) begin
                sm_chan[n_sm] = int'(smp_chan); sm_data[n_sm] = int'(smp_data);
                sm_eoc[n_sm] = int'(eoc); sm_eos[n_sm] = int'(eos); n_sm++;
            end
            if (conv_start && n_st < LOGN) begin
                st_chan[n_st] = int'(conv_chan); st_cyc[n_st] = cyc; n_st++;
                lat = LAT;
            end else if (lat > 0) begin
                lat--;
                if (lat == 0 && n_dn < LOGN) begin
                    conv_done = 1'b1;
                    conv_data = 16'($urandom);
                    dn_data[n_dn] = int'(conv_data); dn_cyc[n_dn] = cyc; n_dn++;
                end
            end
            if (stray_req != stray_ack) begin
                conv_done = 1'b1;
                conv_data = 16'hBEEF;
                stray_ack++;
            end
        end
    end

    function automatic int exp_next(int c, int lo, int hi);
        return (c == hi) ? lo : ((c + 1) & 15);
    endfunction

    function automatic int exp_gap(bit sel);
        return sel ? FAST : SLOW;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_range(int lo, int hi, output int bcnt);
        @(negedge clk);
        range_wr = 1'b1;
        range_data = {4'(hi), 4'(lo)};
        @(negedge clk);
        range_wr = 1'b0;
        bcnt = 0;
        while (busy && bcnt < 1000) begin bcnt++; @(negedge clk); end
    endtask

    task automatic fire(int kind);
        @(negedge clk);
        case (kind)
            0: sw_start = 1'b1;
            1: timer_tick = 1'b1;
            default: ext_pin = 1'b1;
        endcase
        @(negedge clk);
        sw_start = 1'b0; timer_tick = 1'b0; ext_pin = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        @(negedge clk);
        while (busy && k < 5000) begin k++; @(negedge clk); end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_single(int lo, int hi, int kind, string tag);
        int s0 = n_st, m0 = n_sm, d0 = n_dn, f0 = n_bfall;
        int c0 = int'(cur_chan);
        fire(kind);
        wait_idle();
        check(n_st == s0 + 1, {tag, " start count"}, n_st - s0, 1);
        if (n_st > s0) check(st_chan[s0] == c0, {tag, " R3 start channel"}, st_chan[s0], c0);
        check(int'(cur_chan) == exp_next(c0, lo, hi), {tag, " R3 next channel"},
              int'(cur_chan), exp_next(c0, lo, hi));
        check(n_sm == m0 + 1, {tag, " R5 sample count"}, n_sm - m0, 1);
        check(n_bfall == f0 + 1, {tag, " R5 busy pulses"}, n_bfall - f0, 1);
        if (n_sm > m0 && n_dn > d0) begin
            check(sm_data[m0] == dn_data[d0], {tag, " R9 sample data"}, sm_data[m0], dn_data[d0]);
            check(sm_chan[m0] == c0, {tag, " R9 sample channel"}, sm_chan[m0], c0);
            check(sm_eoc[m0] == 1 && sm_eos[m0] == 0, {tag, " R5 eoc with sample"},
                  sm_eoc[m0] * 2 + sm_eos[m0], 2);
        end
    endtask

    task automatic run_scan(int lo, int hi, bit gsel);
        int s0, m0, d0, f0, e0, b;
        int n = hi - lo + 1;
        wr_range(lo, hi, b);
        check(b == SETTLE, "R2 settle before scan", b, SETTLE);
        check(int'(cur_chan) == lo, "R1 scan start channel", int'(cur_chan), lo);
        scan_en = 1'b1; gap_sel = gsel;
        s0 = n_st; m0 = n_sm; d0 = n_dn; f0 = n_bfall; e0 = n_eoc;
        fire(0);
        scan_en = 1'b0;
        wait_idle();
        check(n_st - s0 == n, "R6 scan conversions", n_st - s0, n);
        check(n_sm - m0 == n, "R6 scan samples", n_sm - m0, n);
        check(n_bfall - f0 == 1, "R6 busy held over scan", n_bfall - f0, 1);
        check(n_eoc == e0, "R6 no eoc in scan", n_eoc - e0, 0);
        check(int'(cur_chan) == lo, "R3 scan wraps to low", int'(cur_chan), lo);
        for (int k = 0; k < n && s0 + k < n_st && m0 + k < n_sm; k++) begin
            check(st_chan[s0 + k] == lo + k, "R6 scan channel order", st_chan[s0 + k], lo + k);
            check(sm_eos[m0 + k] == ((k == n - 1) ? 1 : 0), "R6 eos placement",
                  sm_eos[m0 + k], (k == n - 1) ? 1 : 0);
            check(sm_data[m0 + k] == dn_data[d0 + k], "R9 scan data", sm_data[m0 + k], dn_data[d0 + k]);
            if (k > 0)
                check(st_cyc[s0 + k] - dn_cyc[d0 + k - 1] == exp_gap(gsel) + 1, "R7 sample gap",
                      st_cyc[s0 + k] - dn_cyc[d0 + k - 1] - 1, exp_gap(gsel));
        end
    endtask

    initial begin
        int b, s0, lo, hi;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!busy && cur_chan == 4'd0 && !missed && !conv_start && !smp_valid,
              "R10 reset state", int'(busy) + int'(cur_chan) + int'(missed), 0);

        // R1, R2 window 3..6
        wr_range(3, 6, b);
        check(b == SETTLE, "R2 settle length", b, SETTLE);
        check(cur_chan == 4'd3, "R1 low limit loaded", int'(cur_chan), 3);

        // R3, R5, R9 singles crossing the upper limit
        for (int i = 0; i < 5; i++) run_single(3, 6, 0, "R5 sw single");
        check(cur_chan == 4'd4, "R3 wrapped sequence", int'(cur_chan), 4);

        // R4 hardware mode: timer selected
        hw_trig_en = 1'b1; trig_src_sel = 1'b1;
        s0 = n_st;
        fire(0);
        wait_idle();
        check(n_st == s0, "R4 sw start ignored in hw mode", n_st - s0, 0);
        s0 = n_st;
        fire(2);
        wait_idle();
        check(n_st == s0, "R4 pin ignored when timer selected", n_st - s0, 0);
        run_single(3, 6, 1, "R4 timer trigger");

        // R4 pin selected, held high gives one start, tick ignored
        trig_src_sel = 1'b0;
        s0 = n_st;
        @(negedge clk); ext_pin = 1'b1;
        wait_idle();
        repeat (20) @(negedge clk);
        check(n_st == s0 + 1, "R4 held pin one start", n_st - s0, 1);
        s0 = n_st;
        fire(1);
        wait_idle();
        check(n_st == s0, "R4 tick ignored when pin selected", n_st - s0, 0);
        @(negedge clk); ext_pin = 1'b0;
        hw_trig_en = 1'b0;

        // R9 stray done while idle
        s0 = n_sm;
        stray_req++;
        repeat (4) @(negedge clk);
        check(n_sm == s0, "R9 stray done ignored", n_sm - s0, 0);

        // R6, R7 scans with both gaps and a one-channel window
        run_scan(2, 5, 1'b1);
        run_scan(9, 12, 1'b0);
        run_scan(7, 7, 1'b1);
        run_scan(0, 15, 1'b1);

        // random windows and modes
        for (int it = 0; it < 12; it++) begin
            lo = int'($urandom % 16);
            hi = lo + int'($urandom % (16 - lo));
            if ($urandom % 2 == 1) begin
                run_scan(lo, hi, 1'($urandom % 2));
            end else begin
                wr_range(lo, hi, b);
                check(b == SETTLE, "R2 random settle", b, SETTLE);
                check(int'(cur_chan) == lo, "R1 random low", int'(cur_chan), lo);
                run_single(lo, hi, 0, "R5 random single");
                run_single(lo, hi, 0, "R5 random single");
            end
        end

        // R8 trigger while busy
        wr_range(4, 8, b);
        check(!missed, "R8 missed clear before", int'(missed), 0);
        s0 = n_st;
        fire(0);
        fire(0);
        wait_idle();
        check(n_st == s0 + 1, "R8 busy trigger dropped", n_st - s0, 1);
        check(missed, "R8 missed set", int'(missed), 1);
        check(cur_chan == 4'd5, "R8 channel untouched by drop", int'(cur_chan), 5);
        // R8 trigger together with range write
        @(negedge clk); range_wr = 1'b1; range_data = 8'h21; sw_start = 1'b1;
        @(negedge clk); range_wr = 1'b0; sw_start = 1'b0;
        wait_idle();
        check(n_st == s0 + 1, "R8 trigger at range write dropped", n_st - s0, 1);
        check(missed, "R8 missed stays set", int'(missed), 1);

        // R10 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(!busy && cur_chan == 4'd0 && !missed, "R10 reset clears",
              int'(busy) + int'(cur_chan) + int'(missed), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule